// File: doc/BRIEF.md
# Shadow and Sideways Memory Mapper

This block decides, for every CPU bus cycle of an accelerator fitted to a home computer with shadow RAM and paged ROM, where the access is served. It keeps internal copies of two host mapping latches: a paging latch that selects one of sixteen sideways slots and can lay a 4 KB shadow block over the bottom of the sideways window, and an access-control latch that steers screen-area accesses and can lay an 8 KB shadow block over the lower half of the OS ROM area. It also records whether the most recent opcode fetch came from the display-driver region $C000-$DFFF. Screen accesses are mapped differently for driver code and for other code.

Each cycle, the block combines the address with the registered state. It gives a region code, the selected slot, and three flags. The first says whether a write must also go to the host. The second says whether a write must be discarded. The third says whether the current opcode fetch must be repeated on the host bus, so that the host's own driver-region logic follows the change of state. The cache storage, the CPU core and the bus sequencer use these outputs. The classification has no register between the address and the outputs, so it can be answered in the same CPU cycle.

Top module: `shadow_page_mapper`

## Requirements
- R1: After a synchronous reset, both latches and the driver flag are zero. So $3000 maps to main RAM, $8000 maps to slot 0 (external), and $C000 maps to the OS ROM copy.
- R2: Region codes are: 0 main RAM, 1 shadow RAM, 2 OS ROM copy, 3 sideways RAM, 4 sideways ROM, 5 external uncached, 6 I/O. $0000-$2FFF is main RAM. $E000-$FBFF and $FF00-$FFFF are the OS ROM copy.
- R3: Pages $FC, $FD and $FE are I/O (code 6), and every write to them goes to the host. `acc_slow` is 1 exactly for pages $FC and $FD.
- R4: A valid write to any address in $FE30-$FE33 loads the paging latch from `cpu_wdata`. The write does not change the current cycle's classification; it takes effect from the next cycle. `acc_slot` always shows paging latch bits 3:0. A write while `cpu_valid` is 0 has no effect.
- R5: When paging latch bit 7 is 1, $8000-$8FFF is shadow RAM. $9000-$BFFF still follows the selected slot.
- R6: In $8000-$BFFF, slots 4-7 are sideways RAM (code 3). Slots 9-15 are sideways ROM (code 4), and writes to them raise `acc_drop`. Slots 0-3 and 8 are external (code 5), and writes to them go to the host.
- R7: A valid write to any address in $FE34-$FE37 loads the access-control latch. When its bit 3 is 1, $C000-$DFFF is shadow RAM instead of the OS ROM copy. Writes to the OS ROM copy raise `acc_drop`.
- R8: $3000-$7FFF is shadow RAM when the selected control bit is 1, and main RAM when it is 0. Bit 0 is selected while the driver flag is 1, and bit 1 while it is 0.
- R9: The driver flag is updated only by valid cycles with `cpu_sync` high. It becomes 1 when the fetch address is in $C000-$DFFF and 0 otherwise.
- R10: `sync_to_host` is 1 on a valid opcode fetch whose address would change the driver flag, and 0 on every other cycle.
- R11: A write to $3000-$7FFF goes to the host whether it maps to main or shadow RAM. Writes to internal main RAM, shadow RAM outside the screen area, and sideways RAM do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | A CPU bus cycle is present |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | Cycle is a write |
| cpu_sync | input | 1 | Cycle is an opcode fetch |
| cpu_wdata | input | 8 | Write data |
| acc_region | output | 3 | Region code (see R2) |
| acc_slot | output | 4 | Selected sideways slot |
| acc_slow | output | 1 | Access is to the slow expansion pages |
| acc_host_wr | output | 1 | Write must be passed to the host |
| acc_drop | output | 1 | Write must be discarded |
| sync_to_host | output | 1 | Fetch must be shown on the host bus |

## Verification
The address space is swept at region edges ($2FFF/$3000, $8FFF/$9000, $BFFF/$C000, $DFFF/$E000, $FBFF/$FC00, $FEFF/$FF00) under several latch settings. This separates faults in the range compares from faults in the overlay bits. The paging latch is stepped through slots that fall on each side of each policy boundary (3/4, 7/8, 8/9) and is written through aliased addresses. Opcode fetches alternate between the driver region and ordinary code, with repeated fetches and plain reads in between. This separates a flag that follows every access from one that follows only fetches, and a `sync_to_host` that fires on every fetch from one that fires only on transitions.

// File: rtl/smap_pkg.sv
package smap_pkg;

    typedef enum logic [2:0] {
        RG_MAIN   = 3'd0,
        RG_SHADOW = 3'd1,
        RG_MOS    = 3'd2,
        RG_SWRAM  = 3'd3,
        RG_SWROM  = 3'd4,
        RG_EXT    = 3'd5,
        RG_IO     = 3'd6
    } region_e;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 4;

    // control bit positions inside the latches
    localparam int PAGE_OVERLAY_BIT = 7;
    localparam int CTRL_VDU_BIT     = 0;
    localparam int CTRL_USER_BIT    = 1;
    localparam int CTRL_HI_BIT      = 3;

    // latch base addresses (four-byte aliased blocks)
    localparam logic [ADDR_W-1:0] PAGE_LATCH_ADDR = 16'hFE30;
    localparam logic [ADDR_W-1:0] CTRL_LATCH_ADDR = 16'hFE34;

    // sideways slot policy boundaries
    localparam int SW_RAM_FIRST = 4;
    localparam int SW_RAM_LAST  = 7;
    localparam int SW_ROM_FIRST = 9;

    typedef struct packed {
        logic [DATA_W-1:0] page;
        logic [DATA_W-1:0] ctrl;
        logic              vdu;
    } map_state_t;

    function automatic region_e slot_kind(input logic [SLOT_W-1:0] s);
        if (int'(s) >= SW_RAM_FIRST && int'(s) <= SW_RAM_LAST) return RG_SWRAM;
        if (int'(s) >= SW_ROM_FIRST) return RG_SWROM;
        return RG_EXT;
    endfunction

    function automatic logic in_driver_area(input logic [ADDR_W-1:0] a);
        return a[15:13] == 3'b110;
    endfunction

    function automatic logic in_screen_area(input logic [ADDR_W-1:0] a);
        return (a >= 16'h3000) && (a <= 16'h7FFF);
    endfunction

endpackage

// File: rtl/smap_state.sv
module smap_state
    import smap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_sync,
    input  logic [DATA_W-1:0] cpu_wdata,
    output map_state_t        st_q
);
    localparam int ALIAS_W = 2;

    logic hit_page, hit_ctrl;
    assign hit_page = cpu_valid && cpu_we &&
        (cpu_addr[ADDR_W-1:ALIAS_W] == PAGE_LATCH_ADDR[ADDR_W-1:ALIAS_W]);
    assign hit_ctrl = cpu_valid && cpu_we &&
        (cpu_addr[ADDR_W-1:ALIAS_W] == CTRL_LATCH_ADDR[ADDR_W-1:ALIAS_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (hit_page) st_q.page <= cpu_wdata;
            if (hit_ctrl) st_q.ctrl <= cpu_wdata;
            if (cpu_valid && cpu_sync) st_q.vdu <= in_driver_area(cpu_addr);
        end
    end

    assert_page_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr[15:2] == 14'h3F8C) |=> (st_q.page == $past(cpu_wdata)));

    assert_ctrl_load_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr[15:2] == 14'h3F8D) |=> (st_q.ctrl == $past(cpu_wdata)));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_valid && cpu_sync) |=> $stable(st_q.vdu));

endmodule

// File: rtl/smap_decode.sv
module smap_decode
    import smap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  map_state_t        st,
    output region_e           region,
    output logic [SLOT_W-1:0] slot,
    output logic              screen,
    output logic              slow
);
    logic [7:0] pg;
    assign pg     = addr[15:8];
    assign slot   = st.page[SLOT_W-1:0];
    assign screen = in_screen_area(addr);
    assign slow   = (pg == 8'hFC) || (pg == 8'hFD);

    always_comb begin
        region = RG_MAIN;
        if (pg >= 8'hFC && pg <= 8'hFE) begin
            region = RG_IO;
        end else if (in_driver_area(addr)) begin
            region = st.ctrl[CTRL_HI_BIT] ? RG_SHADOW : RG_MOS;
        end else if (addr[15:13] == 3'b111) begin
            region = RG_MOS;
        end else if (addr[15:14] == 2'b10) begin
            if (st.page[PAGE_OVERLAY_BIT] && addr[13:12] == 2'b00)
                region = RG_SHADOW;
            else
                region = slot_kind(slot);
        end else if (screen) begin
            if (st.vdu ? st.ctrl[CTRL_VDU_BIT] : st.ctrl[CTRL_USER_BIT])
                region = RG_SHADOW;
            else
                region = RG_MAIN;
        end
    end

endmodule

// File: rtl/smap_hostctl.sv
module smap_hostctl
    import smap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic              cpu_sync,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  region_e           region,
    input  logic              screen,
    input  logic              vdu_q,
    output logic              host_wr,
    output logic              drop,
    output logic              sync_out
);
    logic wr;
    assign wr = cpu_valid && cpu_we;

    assign host_wr  = wr && (region == RG_IO || region == RG_EXT || screen);
    assign drop     = wr && (region == RG_SWROM || region == RG_MOS);
    assign sync_out = cpu_valid && cpu_sync && (in_driver_area(cpu_addr) != vdu_q);

    assert_io_write_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr[15:8] == 8'hFE) |-> host_wr);

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && drop));

    assert_sync_flip_R10: assert property (@(posedge clk) disable iff (rst)
        sync_out |=> (vdu_q != $past(vdu_q)));

    assert_sync_only_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> (cpu_valid && cpu_sync));

endmodule

// File: rtl/shadow_page_mapper.sv
module shadow_page_mapper
    import smap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_valid,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_we,
    input  logic        cpu_sync,
    input  logic [7:0]  cpu_wdata,
    output logic [2:0]  acc_region,
    output logic [3:0]  acc_slot,
    output logic        acc_slow,
    output logic        acc_host_wr,
    output logic        acc_drop,
    output logic        sync_to_host
);
    map_state_t st_q;
    region_e    region;
    logic       screen;

    smap_state u_state (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_sync(cpu_sync), .cpu_wdata(cpu_wdata), .st_q(st_q)
    );

    smap_decode u_decode (
        .addr(cpu_addr), .st(st_q), .region(region), .slot(acc_slot),
        .screen(screen), .slow(acc_slow)
    );

    smap_hostctl u_host (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_sync(cpu_sync), .cpu_addr(cpu_addr), .region(region),
        .screen(screen), .vdu_q(st_q.vdu), .host_wr(acc_host_wr),
        .drop(acc_drop), .sync_out(sync_to_host)
    );

    assign acc_region = region;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (st_q == '0));

    assert_screen_write_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr >= 16'h3000 && cpu_addr <= 16'h7FFF) |-> acc_host_wr);

endmodule

// File: tb/test_shadow_page_mapper.sv
module test_shadow_page_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_sync = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [2:0]  acc_region;
    logic [3:0]  acc_slot;
    logic        acc_slow, acc_host_wr, acc_drop, sync_to_host;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int m_page = 0;
    int m_ctrl = 0;
    int m_vdu  = 0;

    always #2 clk = ~clk;

    shadow_page_mapper i_shadow_page_mapper (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_sync(cpu_sync), .cpu_wdata(cpu_wdata),
        .acc_region(acc_region), .acc_slot(acc_slot), .acc_slow(acc_slow),
        .acc_host_wr(acc_host_wr), .acc_drop(acc_drop), .sync_to_host(sync_to_host)
    );

    function automatic int ref_region(int a);
        int s;
        if (a >= 'hFC00 && a <= 'hFEFF) return 6;
        if (a >= 'hC000 && a <= 'hDFFF) return ((m_ctrl >> 3) & 1) ? 1 : 2;
        if (a >= 'hE000) return 2;
        if (a >= 'h8000 && a <= 'hBFFF) begin
            if (((m_page >> 7) & 1) && a < 'h9000) return 1;
            s = m_page & 15;
            if (s >= 4 && s <= 7) return 3;
            if (s >= 9) return 4;
            return 5;
        end
        if (a >= 'h3000 && a <= 'h7FFF) begin
            if (m_vdu != 0) return (m_ctrl & 1) ? 1 : 0;
            return ((m_ctrl >> 1) & 1) ? 1 : 0;
        end
        return 0;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s addr=%h actual=%0d expected=%0d", tag, what, cpu_addr, act, exp);
        end
    endtask

    task automatic cyc(string tag, int a, bit v, bit w, bit s, int d);
        int rg, wr, dr, sy, in_drv, scr;
        @(negedge clk);
        cpu_valid = v; cpu_addr = a[15:0]; cpu_we = w; cpu_sync = s; cpu_wdata = d[7:0];
        #1;
        rg = ref_region(a);
        scr = (a >= 'h3000 && a <= 'h7FFF);
        in_drv = (a >= 'hC000 && a <= 'hDFFF);
        wr = (v && w && (rg == 6 || rg == 5 || scr)) ? 1 : 0;
        dr = (v && w && (rg == 4 || rg == 2)) ? 1 : 0;
        sy = (v && s && (in_drv != m_vdu)) ? 1 : 0;
        cmp(tag, "region", int'(acc_region), rg);
        cmp(tag, "slot", int'(acc_slot), m_page & 15);
        cmp(tag, "slow", int'(acc_slow), (a >= 'hFC00 && a <= 'hFDFF) ? 1 : 0);
        cmp(tag, "host_wr", int'(acc_host_wr), wr);
        cmp(tag, "drop", int'(acc_drop), dr);
        cmp(tag, "sync", int'(sync_to_host), sy);
        @(posedge clk);
        if (v && w && (a >> 2) == ('hFE30 >> 2)) m_page = d & 'hFF;
        if (v && w && (a >> 2) == ('hFE34 >> 2)) m_ctrl = d & 'hFF;
        if (v && s) m_vdu = in_drv;
    endtask

    task automatic rd(string tag, int a);  cyc(tag, a, 1, 0, 0, 0); endtask
    task automatic wrt(string tag, int a, int d); cyc(tag, a, 1, 1, 0, d); endtask
    task automatic fetch(string tag, int a); cyc(tag, a, 1, 0, 1, 0); endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset view
        rd("R1", 'h3000); rd("R1", 'h8000); rd("R1", 'hC000); rd("R1", 'h0100);
        // R2 fixed regions and boundaries
        rd("R2", 'h2FFF); rd("R2", 'hE000); rd("R2", 'hFBFF); rd("R2", 'hFF00);
        wrt("R2", 'h1234, 'h55); wrt("R7", 'hE100, 'h11);
        // R3 I/O pages
        wrt("R3", 'hFC00, 1); wrt("R3", 'hFD80, 2); wrt("R3", 'hFEFF, 3); rd("R3", 'hFE00);
        // R4 paging latch, alias, same-cycle and idle behaviour
        wrt("R4", 'hFE32, 'h05); rd("R4", 'h8000); wrt("R4", 'h8000, 9);
        cyc("R4", 'hFE30, 0, 1, 0, 'h0C); rd("R4", 'h8000);
        // R5, R6 overlay and slot policies
        wrt("R5", 'hFE31, 'h8C); rd("R5", 'h8FFF); rd("R5", 'h9000); wrt("R6", 'hA000, 1);
        wrt("R6", 'hFE33, 'h03); rd("R6", 'hBFFF); wrt("R6", 'h8000, 1);
        wrt("R6", 'hFE30, 'h04); wrt("R6", 'h8000, 1);
        wrt("R6", 'hFE30, 'h07); rd("R6", 'hBFFF);
        wrt("R6", 'hFE30, 'h08); wrt("R6", 'h9000, 1);
        wrt("R6", 'hFE30, 'h09); wrt("R6", 'h9000, 1);
        wrt("R6", 'hFE30, 'h0F); rd("R6", 'h8000);
        // R7 upper shadow overlay through alias
        wrt("R7", 'hFE36, 'h08); rd("R7", 'hBFFF); rd("R7", 'hC000); rd("R7", 'hDFFF);
        rd("R7", 'hE000); wrt("R7", 'hC800, 1); wrt("R11", 'hC800, 1);
        // R8-R10 driver flag and screen steering
        wrt("R8", 'hFE35, 'h02); rd("R8", 'h3000); rd("R8", 'h7FFF); rd("R8", 'h8000);
        fetch("R10", 'hC100); rd("R8", 'h3000);
        fetch("R10", 'hC200); rd("R9", 'h1000); rd("R8", 'h5000);
        fetch("R10", 'h0400); rd("R8", 'h3000);
        cyc("R9", 'hC000, 0, 0, 1, 0); rd("R9", 'h3000);
        wrt("R8", 'hFE34, 'h01); rd("R8", 'h3000);
        fetch("R10", 'hDFFF); rd("R8", 'h3000); rd("R8", 'h7FFF);
        // R11 write-through rules
        wrt("R11", 'h4000, 'hAA); fetch("R10", 'hE000); wrt("R11", 'h4000, 'hAA);
        wrt("R11", 'h0200, 1); wrt("R11", 'h2FFF, 1);
        wrt("R11", 'hFE30, 'h85); wrt("R11", 'h8800, 1); wrt("R11", 'hB000, 1);
        // mid-run reset returns to R1 view
        @(negedge clk); rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        m_page = 0; m_ctrl = 0; m_vdu = 0;
        rd("R1", 'h3000); rd("R1", 'h8000); rd("R1", 'hC000); fetch("R1", 'h0100);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule